// File: doc/BRIEF.md
# Frame Status Queue for a Bit-Oriented Serial Receiver

This block keeps a short history of completed receive frames for a bit-oriented (flag-delimited) serial receiver. A 14-bit byte counter runs while the receiver works in the bit-oriented mode. It advances once per received byte and restarts from zero whenever the opening flag of a frame is seen. When the receiver signals the end of a frame, the current count goes into a ten-entry circular queue, together with the three residue bits, the overrun flag and the CRC-error flag. Later frames can then arrive before the host has serviced the earlier ones.

The host sees three byte-wide views through one combinational read port. The first is a status byte. The second is a count-high byte, which also carries the queue's data-available and sticky overflow flags. The third is a count-low byte. While the queue is switched on and holds at least one entry, the status byte and both count bytes show the oldest entry, and a status-byte read strobe retires that entry. Otherwise all three views show the live receiver status and the live counter. The all-sent and parity bits always come straight from the live status.

Top module: `frame_stat_queue`

## Requirements
- R1: While `q_enable` is 1, an `frame_end` pulse stores one entry: the counter value held before that clock edge, plus the live residue, overrun and CRC-error inputs. A byte strobe in the same cycle is counted after the value has been captured.
- R2: The byte counter adds 1 for each cycle in which `byte_stb` is 1 and `framed_mode` is 1. It holds while `framed_mode` is 0. It saturates at 16383. A `flag_seen` pulse clears it to 0 and takes priority over a byte strobe in the same cycle.
- R3: The queue holds up to 10 entries and returns them oldest first.
- R4: A cycle with `rd_stb`=1 and `rd_sel`=0, while the queue is enabled and not empty, retires the oldest entry at that clock edge. Reads with `rd_sel` 1, 2 or 3 never retire an entry. A status read strobe on an empty queue changes nothing.
- R5: Status byte layout, when taken from the queue:
  - bit 7 = 1 (end of frame)
  - bit 6 = stored CRC error
  - bit 5 = stored overrun
  - bit 4 = live parity
  - bits 3:1 = stored residue
  - bit 0 = live all-sent
- R6: When the queue is empty or disabled, the status byte is {live end-of-frame, live CRC error, live overrun, live parity, live residue[2:0], live all-sent}, and both count bytes show the live counter.
- R7: Count-high byte:
  - bit 7 = sticky overflow flag
  - bit 6 = 1 exactly when the queue is enabled and not empty
  - bits 5:0 = count bits 13:8

  The count-low byte is count bits 7:0. `rd_sel`=3 reads 0x00.
- R8: An end-of-frame pulse into a full queue, with no retire in the same cycle, discards the new entry, keeps all stored entries and sets the overflow flag.
- R9: While `q_enable` is 0, the queue is emptied and the overflow flag is cleared at each clock edge, and `frame_end` pulses store nothing.
- R10: A store and a retire in the same cycle both take effect. On a full queue this leaves 10 entries, adds the new one last and does not set the overflow flag.
- R11: After reset, the queue is empty, the overflow flag is 0 and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| q_enable | input | 1 | Queue enable; 0 empties the queue and clears overflow |
| framed_mode | input | 1 | Byte counting allowed when 1 |
| byte_stb | input | 1 | One received byte |
| flag_seen | input | 1 | Opening flag detected; clears the counter |
| frame_end | input | 1 | End-of-frame pulse; stores an entry |
| live_residue | input | 3 | Live residue bits |
| live_overrun | input | 1 | Live overrun flag |
| live_crc_err | input | 1 | Live CRC-error flag |
| live_all_sent | input | 1 | Live all-sent flag |
| live_parity | input | 1 | Live parity-error flag |
| live_eof | input | 1 | Live end-of-frame flag |
| rd_stb | input | 1 | Host read strobe |
| rd_sel | input | 2 | View select: 0 status, 1 count high, 2 count low, 3 none |
| rd_data | output | 8 | Selected view, combinational |

## Verification
The assertions cover the per-cycle rules of the queue:
- occupancy never exceeds 10, and a retire without a store lowers it by one;
- a store into a full queue without a retire leaves it full and raises the overflow flag;
- disabling empties the queue on the next edge, and the overflow flag holds while the queue is enabled;
- the counter is zero after a flag;
- the data-available bit and the end-of-frame bit follow the occupancy.

Only the bench scenarios can show that stored entries come back in order with the right count and status fields. The same holds for capture before a same-cycle byte strobe, counter saturation, and the entry order after a simultaneous store and retire on a full queue.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

  localparam int unsigned FSQ_CNT_W = 14;

  typedef struct packed {
    logic [FSQ_CNT_W-1:0] count;
    logic [2:0]           residue;
    logic                 overrun;
    logic                 crc_err;
  } fsq_entry_t;

  typedef enum logic [1:0] {
    SEL_STAT   = 2'd0,
    SEL_CNT_HI = 2'd1,
    SEL_CNT_LO = 2'd2,
    SEL_NONE   = 2'd3
  } fsq_sel_e;

endpackage

// File: rtl/fsq_byte_counter.sv
module fsq_byte_counter #(
  parameter int unsigned W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         framed_mode,
  input  logic         byte_stb,
  input  logic         flag_seen,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic         cnt_en;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_en = flag_seen | (framed_mode & byte_stb & (count != CNT_MAX));
    cnt_d  = flag_seen ? '0 : count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_en) count <= cnt_d;
  end
endmodule

// File: rtl/fsq_ring.sv
module fsq_ring
  import fsq_pkg::*;
#(
  parameter int unsigned DEPTH = 10,
  parameter int unsigned PTR_W = $clog2(DEPTH),
  parameter int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             push_req,
  input  logic             pop_req,
  input  fsq_entry_t       wr_entry,
  output fsq_entry_t       head_entry,
  output logic [OCC_W-1:0] occ,
  output logic             empty,
  output logic             push_acc,
  output logic             pop_acc,
  output logic             ovf
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);

  fsq_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q, head_d, tail_d;
  logic [OCC_W-1:0] occ_d;
  logic             ovf_d, full;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    empty    = (occ == '0);
    full     = (occ == FULL_OCC);
    pop_acc  = enable & pop_req & ~empty;
    push_acc = enable & push_req & (~full | pop_acc);
    if (!enable) begin
      head_d = '0;
      tail_d = '0;
      occ_d  = '0;
      ovf_d  = 1'b0;
    end else begin
      head_d = pop_acc  ? ptr_inc(head_q) : head_q;
      tail_d = push_acc ? ptr_inc(tail_q) : tail_q;
      occ_d  = occ + OCC_W'(push_acc) - OCC_W'(pop_acc);
      ovf_d  = ovf | (push_req & full & ~pop_acc);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ    <= '0;
      ovf    <= 1'b0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      occ    <= occ_d;
      ovf    <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_acc) mem[tail_q] <= wr_entry;
  end

  assign head_entry = mem[head_q];
endmodule

// File: rtl/fsq_read_mux.sv
module fsq_read_mux
  import fsq_pkg::*;
(
  input  logic                 use_q,
  input  logic [1:0]           rd_sel,
  input  fsq_entry_t           head_entry,
  input  logic [FSQ_CNT_W-1:0] live_count,
  input  logic [2:0]           live_residue,
  input  logic                 live_overrun,
  input  logic                 live_crc_err,
  input  logic                 live_all_sent,
  input  logic                 live_parity,
  input  logic                 live_eof,
  input  logic                 ovf,
  output logic [7:0]           rd_data
);
  logic [7:0]           stat_byte;
  logic [FSQ_CNT_W-1:0] cnt_src;

  always_comb begin
    if (use_q) begin
      stat_byte = {1'b1, head_entry.crc_err, head_entry.overrun, live_parity,
                   head_entry.residue, live_all_sent};
      cnt_src   = head_entry.count;
    end else begin
      stat_byte = {live_eof, live_crc_err, live_overrun, live_parity,
                   live_residue, live_all_sent};
      cnt_src   = live_count;
    end
    unique case (fsq_sel_e'(rd_sel))
      SEL_STAT:   rd_data = stat_byte;
      SEL_CNT_HI: rd_data = {ovf, use_q, cnt_src[FSQ_CNT_W-1:8]};
      SEL_CNT_LO: rd_data = cnt_src[7:0];
      default:    rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/frame_stat_queue.sv
module frame_stat_queue
  import fsq_pkg::*;
#(
  parameter int unsigned DEPTH = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       q_enable,
  input  logic       framed_mode,
  input  logic       byte_stb,
  input  logic       flag_seen,
  input  logic       frame_end,
  input  logic [2:0] live_residue,
  input  logic       live_overrun,
  input  logic       live_crc_err,
  input  logic       live_all_sent,
  input  logic       live_parity,
  input  logic       live_eof,
  input  logic       rd_stb,
  input  logic [1:0] rd_sel,
  output logic [7:0] rd_data
);
  localparam int unsigned OCC_W = $clog2(DEPTH + 1);

  logic                 rst_meta_n, rst_sync_n;
  logic [FSQ_CNT_W-1:0] byte_count;
  fsq_entry_t           wr_entry, head_entry;
  logic [OCC_W-1:0]     occ;
  logic                 empty, push_acc, pop_acc, ovf, use_q, pop_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  fsq_byte_counter #(.W(FSQ_CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .framed_mode(framed_mode),
    .byte_stb(byte_stb), .flag_seen(flag_seen), .count(byte_count)
  );

  always_comb begin
    wr_entry.count   = byte_count;
    wr_entry.residue = live_residue;
    wr_entry.overrun = live_overrun;
    wr_entry.crc_err = live_crc_err;
    pop_req          = rd_stb & (rd_sel == SEL_STAT);
    use_q            = q_enable & ~empty;
  end

  fsq_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_sync_n), .enable(q_enable),
    .push_req(frame_end), .pop_req(pop_req), .wr_entry(wr_entry),
    .head_entry(head_entry), .occ(occ), .empty(empty),
    .push_acc(push_acc), .pop_acc(pop_acc), .ovf(ovf)
  );

  fsq_read_mux u_mux (
    .use_q(use_q), .rd_sel(rd_sel), .head_entry(head_entry),
    .live_count(byte_count), .live_residue(live_residue),
    .live_overrun(live_overrun), .live_crc_err(live_crc_err),
    .live_all_sent(live_all_sent), .live_parity(live_parity),
    .live_eof(live_eof), .ovf(ovf), .rd_data(rd_data)
  );
endmodule

// File: rtl/fsq_checker.sv
module fsq_checker #(
  parameter int unsigned DEPTH = 10,
  parameter int unsigned OCC_W = 4,
  parameter int unsigned CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             q_enable,
  input logic             flag_seen,
  input logic             frame_end,
  input logic [1:0]       rd_sel,
  input logic [7:0]       rd_data,
  input logic [OCC_W-1:0] occ,
  input logic             push_acc,
  input logic             pop_acc,
  input logic             ovf,
  input logic [CNT_W-1:0] byte_count
);
  localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= FULL_OCC); // R3
  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_acc && !push_acc) |=> occ == $past(occ) - 1'b1); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (q_enable && frame_end && occ == FULL_OCC && !pop_acc) |=> (occ == FULL_OCC && ovf)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (q_enable && ovf) |=> ovf); // R7
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !q_enable |=> (occ == '0 && !ovf)); // R9
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flag_seen |=> byte_count == '0); // R2
  AST_AVAIL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 2'd1) |-> rd_data[6] == (q_enable && occ != '0)); // R7
  AST_EOF_FROM_Q: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 2'd0 && q_enable && occ != '0) |-> rd_data[7]); // R5
endmodule

bind frame_stat_queue fsq_checker #(.DEPTH(DEPTH), .OCC_W(OCC_W), .CNT_W(fsq_pkg::FSQ_CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .q_enable(q_enable), .flag_seen(flag_seen),
  .frame_end(frame_end), .rd_sel(rd_sel), .rd_data(rd_data), .occ(occ),
  .push_acc(push_acc), .pop_acc(pop_acc), .ovf(ovf), .byte_count(byte_count)
);

// File: tb/sim_frame_stat_queue.sv
module sim_frame_stat_queue;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic q_enable = 1'b0, framed_mode = 1'b1, byte_stb = 1'b0, flag_seen = 1'b0, frame_end = 1'b0;
  logic [2:0] live_residue = 3'd0;
  logic live_overrun = 1'b0, live_crc_err = 1'b0, live_all_sent = 1'b0, live_parity = 1'b0, live_eof = 1'b0;
  logic rd_stb = 1'b0;
  logic [1:0] rd_sel = 2'd0;
  logic [7:0] rd_data;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // bench model
  logic [18:0] mq[$];
  int unsigned mcnt = 0;
  logic movf = 1'b0;

  always #10 clk = ~clk;

  frame_stat_queue u0 (
    .clk(clk), .rst_n(rst_n), .q_enable(q_enable), .framed_mode(framed_mode),
    .byte_stb(byte_stb), .flag_seen(flag_seen), .frame_end(frame_end),
    .live_residue(live_residue), .live_overrun(live_overrun), .live_crc_err(live_crc_err),
    .live_all_sent(live_all_sent), .live_parity(live_parity), .live_eof(live_eof),
    .rd_stb(rd_stb), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  function automatic logic [7:0] exp_view(input logic [1:0] sel);
    logic [18:0] e;
    logic        useq;
    logic [13:0] c;
    useq = q_enable && (mq.size() > 0);
    e    = useq ? mq[0] : 19'd0;
    c    = useq ? e[13:0] : 14'(mcnt);
    case (sel)
      2'd0: return useq ? {1'b1, e[18], e[17], live_parity, e[16:14], live_all_sent}
                        : {live_eof, live_crc_err, live_overrun, live_parity, live_residue, live_all_sent};
      2'd1: return {movf, useq, c[13:8]};
      2'd2: return c[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic rd(input logic [1:0] sel, input logic stb, input string req);
    logic [7:0] exp;
    logic [7:0] act;
    @(negedge clk);
    rd_sel = sel;
    rd_stb = stb;
    #1;
    exp = exp_view(sel);
    act = rd_data;
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s sel=%0d actual=%02h expected=%02h", req, sel, act, exp);
    end
    if (stb && sel == 2'd0 && q_enable && mq.size() > 0) void'(mq.pop_front());
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic flag();
    @(negedge clk); flag_seen = 1'b1;
    @(negedge clk); flag_seen = 1'b0;
    mcnt = 0;
  endtask

  task automatic bytes(input int n);
    if (n > 0) begin
      @(negedge clk); byte_stb = 1'b1;
      repeat (n) @(negedge clk);
      byte_stb = 1'b0;
      if (framed_mode) mcnt = (mcnt + n > 16383) ? 16383 : mcnt + n;
    end
  endtask

  task automatic eof(input logic [2:0] res, input logic ovr, input logic crc);
    @(negedge clk);
    live_residue = res; live_overrun = ovr; live_crc_err = crc; frame_end = 1'b1;
    if (q_enable) begin
      if (mq.size() < 10) mq.push_back({crc, ovr, res, 14'(mcnt)});
      else movf = 1'b1;
    end
    @(negedge clk); frame_end = 1'b0;
    live_residue = ~res; live_overrun = ~ovr; live_crc_err = ~crc;
  endtask

  task automatic frame(input int k);
    flag();
    bytes(k * 97 + 5);
    eof(3'(k % 8), 1'(k), 1'(k >> 1));
  endtask

  task automatic set_en(input logic en);
    @(negedge clk); q_enable = en;
    if (!en) begin mq.delete(); movf = 1'b0; end
    @(negedge clk);
  endtask

  task automatic drain(input string req);
    while (mq.size() > 0) begin
      rd(2'd1, 1'b0, req);
      rd(2'd2, 1'b0, req);
      rd(2'd0, 1'b1, req);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11: reset state, all views live
    rd(2'd0, 1'b0, "R11");
    rd(2'd1, 1'b0, "R11");
    rd(2'd2, 1'b0, "R11");
    rd(2'd3, 1'b0, "R7");

    // R2: counting, mode gating, flag priority
    flag(); bytes(300);
    rd(2'd1, 1'b0, "R2"); rd(2'd2, 1'b0, "R2");
    framed_mode = 1'b0; bytes(5); framed_mode = 1'b1;
    rd(2'd2, 1'b0, "R2");
    @(negedge clk); flag_seen = 1'b1; byte_stb = 1'b1;
    @(negedge clk); flag_seen = 1'b0; byte_stb = 1'b0; mcnt = 0;
    rd(2'd2, 1'b0, "R2");
    // R6: live status sweep with queue disabled
    for (int v = 0; v < 256; v += 37) begin
      {live_eof, live_crc_err, live_overrun, live_parity, live_residue, live_all_sent} = 8'(v);
      rd(2'd0, 1'b1, "R6");
    end
    // R9: frame_end ignored while disabled
    frame(3);
    rd(2'd1, 1'b0, "R9");

    // R1 R3 R5: fill sweep
    live_all_sent = 1'b1; live_parity = 1'b0; live_eof = 1'b0;
    set_en(1'b1);
    for (int k = 0; k < 10; k++) frame(k);
    rd(2'd1, 1'b0, "R3");
    // R8: eleventh frame dropped, overflow set
    frame(10);
    rd(2'd1, 1'b0, "R8");
    live_parity = 1'b1;
    drain("R5");
    // R6 R7: empty after drain, sticky overflow, live count
    rd(2'd1, 1'b0, "R7");
    rd(2'd2, 1'b0, "R6");
    rd(2'd0, 1'b1, "R6");
    // R4: status strobe on empty queue changes nothing
    rd(2'd0, 1'b1, "R4");
    frame(2);
    rd(2'd1, 1'b1, "R4");
    rd(2'd2, 1'b1, "R4");
    rd(2'd0, 1'b1, "R4");
    rd(2'd1, 1'b0, "R4");

    // R9: disable clears overflow and entries
    frame(4); frame(5);
    set_en(1'b0);
    set_en(1'b1);
    rd(2'd1, 1'b0, "R9");
    rd(2'd0, 1'b0, "R9");

    // R1: frame_end with a same-cycle byte strobe captures the earlier count
    flag(); bytes(4);
    @(negedge clk); byte_stb = 1'b1; frame_end = 1'b1;
    live_residue = 3'd5; live_overrun = 1'b0; live_crc_err = 1'b1;
    mq.push_back({1'b1, 1'b0, 3'd5, 14'(mcnt)});
    @(negedge clk); byte_stb = 1'b0; frame_end = 1'b0; mcnt = mcnt + 1;
    rd(2'd2, 1'b0, "R1");
    rd(2'd0, 1'b1, "R1");
    rd(2'd2, 1'b0, "R1");

    // R10: simultaneous store and retire on a full queue
    for (int k = 20; k < 30; k++) frame(k);
    flag(); bytes(77);
    @(negedge clk);
    rd_sel = 2'd0; rd_stb = 1'b1; frame_end = 1'b1;
    live_residue = 3'd6; live_overrun = 1'b1; live_crc_err = 1'b0;
    #1;
    n_chk++;
    if (rd_data !== exp_view(2'd0)) begin
      n_fail++;
      $display("FAIL R10 actual=%02h expected=%02h", rd_data, exp_view(2'd0));
    end
    void'(mq.pop_front());
    mq.push_back({1'b0, 1'b1, 3'd6, 14'(mcnt)});
    @(negedge clk); rd_stb = 1'b0; frame_end = 1'b0;
    rd(2'd1, 1'b0, "R10");
    drain("R10");
    rd(2'd1, 1'b0, "R10");

    // R2: saturation
    set_en(1'b0);
    flag(); bytes(16390);
    rd(2'd1, 1'b0, "R2");
    rd(2'd2, 1'b0, "R2");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule